// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host-side master for a serial link to a 12-bit, four-channel sampling converter. The host hands it a 16-bit control word with a one-cycle start pulse. The controller then runs one frame. It drives chip select low and shifts the control word out MSB first. At the same time it shifts in the 16-bit word the converter returns, using exactly sixteen serial clock periods. It then releases chip select and returns the received word with a one-cycle done pulse.

The serial clock is divided from the system clock with a 50% duty cycle. Its rate is clamped between 10 kHz and 20 MHz. Every minimum interval the converter needs is counted in system clock cycles, rounded up from a nanosecond parameter. These intervals are the chip-select lead before the first clock edge, the chip-select hold after the last falling edge, the quiet gap between frames, and the power-up wait after a shutdown request.

Two flags in the control word matter to the controller. One selects the result coding, and the controller uses it to sign-extend or zero-extend the 12-bit sample. The other requests power-down, and it makes the controller hold off the next frame until the power-up interval has passed.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted and after reset, `cs_n` is 1, `sclk` is 1, and `busy` and `done` are 0.
- R2: Each frame holds `cs_n` low for exactly 16 falling edges of `sclk`, and `sclk` stays high whenever `cs_n` is high.
- R3: Each high and low phase of `sclk` inside a frame lasts `HALF` system cycles. `HALF` is ceil(CLK_HZ / (2·SCLK_HZ)), clamped so that the serial rate lies between 10 kHz and 20 MHz. With the bench build this gives 25 ns per phase.
- R4: `mosi` carries `ctrl_word` MSB first. The first bit is valid when `cs_n` falls. After that, `mosi` changes only on rising edges of `sclk`, at least 10 ns before and at least 5 ns after each falling edge.
- R5: `miso` is sampled at each falling edge of `sclk`, MSB first, and the 16 bits appear on `rx_word` when `done` is high.
- R6: At least `LEAD_NS` (never below 10 ns) passes from `cs_n` falling to the first falling edge of `sclk`.
- R7: `cs_n` rises no sooner than `CS_HOLD_NS` (20 ns) after the sixteenth falling edge of `sclk`.
- R8: `done` pulses for one cycle in the cycle `cs_n` rises. `busy` stays high through a quiet time of at least `QUIET_NS` (50 ns), and `cs_n` cannot fall again before that time is over.
- R9: After reset, and after any frame whose control word has bit 4 (power-down request) set, `cs_n` stays high for at least `PWRUP_NS` (1 µs) after start is accepted before the next frame begins.
- R10: Bit 0 of the control word selects coding. When it is 0, `result` is `rx_word[11:0]` sign-extended to 16 bits and `result_signed` is 1. When it is 1, `result` is `rx_word[11:0]` zero-extended and `result_signed` is 0.
- R11: A start pulse while `busy` is high is ignored: no extra frame is run and no extra `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a frame |
| ctrl_word | input | 16 | Control word sent to the converter, sampled with `start` |
| busy | output | 1 | High from an accepted start until the quiet time ends |
| done | output | 1 | One-cycle pulse when `rx_word` and `result` are valid |
| rx_word | output | 16 | Raw word received from the converter |
| result | output | 16 | 12-bit sample extended to 16 bits per the coding flag |
| result_signed | output | 1 | 1 when `result` is two's complement |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
The bench builds the controller with a 200 MHz system clock and asks for a 25 MHz serial rate. This request lies above the 20 MHz ceiling, so it exercises the clamp and should produce 25 ns phases instead of 20 ns. The default interval parameters give a 1 µs power-up wait of about 200 cycles and a quiet gap of about ten cycles. Power-down frames and back-to-back frames therefore both fit in a short run. A converter model in the bench measures each pin edge in real time against the nanosecond limits. It also returns response words chosen to cover both sign cases under both codings.

// File: rtl/adc_frame_pkg.sv
`timescale 1ns/1ps
package adc_frame_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_PWRUP,
    FS_LEAD,
    FS_SHIFT,
    FS_TAIL,
    FS_HOLD,
    FS_QUIET
  } frm_state_e;

  localparam longint unsigned SCLK_CEIL_HZ  = 64'd20_000_000;
  localparam longint unsigned SCLK_FLOOR_HZ = 64'd10_000;

  // Nanoseconds to system cycles, rounded up.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_hz);
    longint unsigned prod;
    prod = 64'(ns) * 64'(clk_hz);
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Half serial period in system cycles, clamped to the legal serial rate band.
  function automatic int unsigned sclk_half_cycles(input int unsigned clk_hz, input int unsigned sclk_hz);
    longint unsigned twice;
    longint unsigned want;
    longint unsigned lo;
    longint unsigned hi;
    twice = 64'(sclk_hz) * 64'd2;
    want  = (64'(clk_hz) + twice - 64'd1) / twice;
    lo    = (64'(clk_hz) + 64'd2 * SCLK_CEIL_HZ - 64'd1) / (64'd2 * SCLK_CEIL_HZ);
    hi    = 64'(clk_hz) / (64'd2 * SCLK_FLOOR_HZ);
    if (want < lo) want = lo;
    if (want > hi) want = hi;
    if (want == 64'd0) want = 64'd1;
    return 32'(want);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
  parameter int unsigned HALF = 5,
  parameter int unsigned CW   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);

  logic [CW-1:0] phase_cnt;
  logic          sclk_q;
  logic          tick;

  assign tick = run && (phase_cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_cnt <= '0;
      sclk_q    <= 1'b1;
    end else if (!run) begin
      phase_cnt <= '0;
      sclk_q    <= 1'b1;
    end else if (tick) begin
      phase_cnt <= '0;
      sclk_q    <= ~sclk_q;
    end else begin
      phase_cnt <= phase_cnt + 1'b1;
    end
  end

  assign sclk     = sclk_q;
  assign fall_evt = tick & sclk_q;
  assign rise_evt = tick & ~sclk_q;

endmodule

// File: rtl/adc_interval_timer.sv
`timescale 1ns/1ps
module adc_interval_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/adc_shift_engine.sv
`timescale 1ns/1ps
module adc_shift_engine #(
  parameter int unsigned W    = 16,
  parameter int unsigned CNTW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift_out,
  input  logic         sample_in,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word,
  output logic         last_fall
);

  logic [W-1:0]    tx_sr;
  logic [W-1:0]    rx_sr;
  logic [CNTW-1:0] fall_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      fall_cnt <= '0;
    end else if (load) begin
      tx_sr    <= load_word;
      rx_sr    <= '0;
      fall_cnt <= '0;
    end else begin
      if (shift_out) tx_sr <= {tx_sr[W-2:0], 1'b0};
      if (sample_in) begin
        rx_sr    <= {rx_sr[W-2:0], miso};
        fall_cnt <= fall_cnt + 1'b1;
      end
    end
  end

  assign mosi      = tx_sr[W-1];
  assign rx_word   = rx_sr;
  assign last_fall = sample_in && (fall_cnt == CNTW'(W - 1));

endmodule

// File: rtl/adc_frame_ctrl.sv
`timescale 1ns/1ps
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned SCLK_HZ    = 20_000_000,
  parameter int unsigned LEAD_NS    = 40,
  parameter int unsigned CS_HOLD_NS = 20,
  parameter int unsigned QUIET_NS   = 50,
  parameter int unsigned PWRUP_NS   = 1000,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned CODING_BIT = 0,
  parameter int unsigned PD_BIT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] ctrl_word,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] result,
  output logic              result_signed,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  localparam int unsigned HALF    = sclk_half_cycles(CLK_HZ, SCLK_HZ);
  localparam int unsigned CW      = $clog2(HALF + 1);
  localparam int unsigned T_LEAD  = max2(ns_to_cycles(LEAD_NS, CLK_HZ), ns_to_cycles(10, CLK_HZ));
  localparam int unsigned T_HOLD  = ns_to_cycles(CS_HOLD_NS, CLK_HZ);
  localparam int unsigned T_QUIET = ns_to_cycles(QUIET_NS, CLK_HZ);
  localparam int unsigned T_PWRUP = ns_to_cycles(PWRUP_NS, CLK_HZ);
  localparam int unsigned T_MAX   = max2(max2(T_LEAD, T_HOLD), max2(T_QUIET, T_PWRUP));
  localparam int unsigned TW      = $clog2(T_MAX + 1);
  localparam int unsigned CNTW    = $clog2(WORD_W + 1);

  function automatic logic [WORD_W-1:0] fmt_result(input logic [DATA_W-1:0] data, input logic straight);
    if (straight) return {{(WORD_W - DATA_W){1'b0}}, data};
    return {{(WORD_W - DATA_W){data[DATA_W-1]}}, data};
  endfunction

  frm_state_e state_q, state_n;
  logic              coding_q, pd_q, pwr_ok_q;
  logic              cs_n_q, done_q, signed_q;
  logic [WORD_W-1:0] rx_q, result_q;

  // Named internal events
  logic              accept;
  logic              sclk_run;
  logic              sclk_rise, sclk_fall;
  logic              bit_shift, bit_sample;
  logic              last_fall;
  logic              frame_close;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic [WORD_W-1:0] eng_rx;

  assign accept      = start && (state_q == FS_IDLE);
  assign sclk_run    = (state_q == FS_SHIFT) || (state_q == FS_TAIL);
  assign bit_shift   = sclk_rise && (state_q == FS_SHIFT);
  assign bit_sample  = sclk_fall && (state_q == FS_SHIFT);
  assign frame_close = (state_q == FS_HOLD) && tmr_zero;

  adc_sclk_gen #(.HALF(HALF), .CW(CW)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sclk_run),
    .sclk     (sclk),
    .rise_evt (sclk_rise),
    .fall_evt (sclk_fall)
  );

  adc_interval_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  adc_shift_engine #(.W(WORD_W), .CNTW(CNTW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (ctrl_word),
    .shift_out (bit_shift),
    .sample_in (bit_sample),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (eng_rx),
    .last_fall (last_fall)
  );

  always_comb begin
    state_n  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      FS_IDLE: if (start) begin
        tmr_load = 1'b1;
        if (pwr_ok_q) begin
          state_n = FS_LEAD;
          tmr_val = TW'(T_LEAD);
        end else begin
          state_n = FS_PWRUP;
          tmr_val = TW'(T_PWRUP);
        end
      end
      FS_PWRUP: if (tmr_zero) begin
        state_n  = FS_LEAD;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_LEAD);
      end
      FS_LEAD:  if (tmr_zero) state_n = FS_SHIFT;
      FS_SHIFT: if (last_fall) state_n = FS_TAIL;
      FS_TAIL:  if (sclk_rise) begin
        state_n  = FS_HOLD;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_HOLD);
      end
      FS_HOLD: if (tmr_zero) begin
        state_n  = FS_QUIET;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_QUIET);
      end
      FS_QUIET: if (tmr_zero) state_n = FS_IDLE;
      default:  state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      coding_q <= 1'b0;
      pd_q     <= 1'b0;
      pwr_ok_q <= 1'b0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      signed_q <= 1'b0;
      rx_q     <= '0;
      result_q <= '0;
    end else begin
      state_q <= state_n;
      cs_n_q  <= !((state_n == FS_LEAD) || (state_n == FS_SHIFT) ||
                   (state_n == FS_TAIL) || (state_n == FS_HOLD));
      done_q  <= frame_close;
      if (accept) begin
        coding_q <= ctrl_word[CODING_BIT];
        pd_q     <= ctrl_word[PD_BIT];
      end
      if (frame_close) begin
        rx_q     <= eng_rx;
        result_q <= fmt_result(eng_rx[DATA_W-1:0], coding_q);
        signed_q <= !coding_q;
        pwr_ok_q <= !pd_q;
      end
    end
  end

  assign busy          = (state_q != FS_IDLE);
  assign done          = done_q;
  assign rx_word       = rx_q;
  assign result        = result_q;
  assign result_signed = signed_q;
  assign cs_n          = cs_n_q;

endmodule

// File: rtl/adc_frame_checks.sv
`timescale 1ns/1ps
module adc_frame_checks #(
  parameter int unsigned T_LEAD  = 8,
  parameter int unsigned T_QUIET = 10,
  parameter int unsigned T_PWRUP = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       pd_req,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       fall_evt,
  input logic [4:0] result_top,
  input logic       result_signed
);

  logic [15:0] high_cnt, lead_cnt, wait_cnt;
  logic [4:0]  fall_cnt;
  logic        pend_pwrup, frame_pd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_cnt   <= 16'hFFFF;
      lead_cnt   <= '0;
      wait_cnt   <= '0;
      fall_cnt   <= '0;
      pend_pwrup <= 1'b1;
      frame_pd   <= 1'b0;
    end else begin
      if (!cs_n) high_cnt <= '0;
      else if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 1'b1;
      if (cs_n) lead_cnt <= '0;
      else if (lead_cnt != 16'hFFFF) lead_cnt <= lead_cnt + 1'b1;
      if (cs_n) fall_cnt <= '0;
      else if (fall_evt) fall_cnt <= fall_cnt + 1'b1;
      if (start && !busy) begin
        wait_cnt <= '0;
        frame_pd <= pd_req;
      end else if (cs_n && wait_cnt != 16'hFFFF) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
      if (done) pend_pwrup <= frame_pd;
      else if (!cs_n) pend_pwrup <= 1'b0;
    end
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  p_sixteen_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (fall_cnt == 5'd16));

  p_mosi_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $rose(sclk));

  p_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && fall_cnt == 5'd0) |-> (lead_cnt >= 16'(T_LEAD)));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (high_cnt >= 16'(T_QUIET)));

  p_done_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(cs_n) && busy));

  p_pwrup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && pend_pwrup) |-> (wait_cnt >= 16'(T_PWRUP)));

  p_signed_fmt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_signed) |-> (result_top == {5{result_top[0]}}));

  p_straight_fmt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !result_signed) |-> (result_top[4:1] == 4'd0));

endmodule

bind adc_frame_ctrl adc_frame_checks #(
  .T_LEAD  (T_LEAD),
  .T_QUIET (T_QUIET),
  .T_PWRUP (T_PWRUP)
) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .pd_req        (ctrl_word[PD_BIT]),
  .busy          (busy),
  .done          (done),
  .cs_n          (cs_n),
  .sclk          (sclk),
  .mosi          (mosi),
  .fall_evt      (sclk_fall),
  .result_top    (result[15:11]),
  .result_signed (result_signed)
);

// File: tb/adc_frame_ctrl_test.sv
`timescale 1ns/1ps
module adc_frame_ctrl_test;

  typedef struct {
    logic [15:0] ctrl;
    logic [15:0] resp;
    logic [15:0] exp_result;
    logic        exp_signed;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic        miso = 1'b0;
  wire         busy, done, result_signed, cs_n, sclk, mosi;
  wire  [15:0] rx_word, result;

  int n_checks = 0;
  int n_fail = 0;
  int pushed = 0;
  int frames_seen = 0;
  bit finished = 0;

  item_t done_q[$];
  item_t model_q[$];

  always #2.5 clk = ~clk;

  adc_frame_ctrl #(.CLK_HZ(200_000_000), .SCLK_HZ(25_000_000)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .busy(busy), .done(done), .rx_word(rx_word), .result(result),
    .result_signed(result_signed), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- converter model ----------------
  real   t_cs_fall = 0.0, t_cs_rise = 0.0, t_last_edge = 0.0, t_last_fall = 0.0;
  real   t_mosi = 0.0, t_down = 0.0;
  int    nfall = 0;
  bit    in_frame = 0, was_frame = 0, down = 1;
  logic [15:0] rx_ctrl = '0;
  item_t cur;

  always @(mosi) t_mosi = $realtime;

  always @(negedge cs_n) begin
    if (rst_n) begin
      frames_seen++;
      in_frame = 1;
      nfall = 0;
      rx_ctrl = '0;
      check(model_q.size() != 0, "R11 unexpected frame", model_q.size(), 1);
      if (model_q.size() != 0) cur = model_q.pop_front();
      if (was_frame)
        check(($realtime - t_cs_rise) >= 50.0, "R8 quiet ns", $rtoi($realtime - t_cs_rise), 50);
      if (down)
        check(($realtime - t_down) >= 1000.0, "R9 power-up ns", $rtoi($realtime - t_down), 1000);
      t_cs_fall = $realtime;
      #20 miso = cur.resp[15];
    end
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      nfall++;
      if (nfall == 1)
        check(($realtime - t_cs_fall) >= 10.0, "R6 lead ns", $rtoi($realtime - t_cs_fall), 10);
      else
        check(($realtime - t_last_edge) > 24.9 && ($realtime - t_last_edge) < 25.1,
              "R3 sclk high phase ns", $rtoi($realtime - t_last_edge), 25);
      check(($realtime - t_mosi) >= 10.0, "R4 mosi setup ns", $rtoi($realtime - t_mosi), 10);
      rx_ctrl = {rx_ctrl[14:0], mosi};
      t_last_fall = $realtime;
      t_last_edge = $realtime;
      if (nfall < 16) begin
        automatic int idx = 15 - nfall;
        #15 miso = cur.resp[idx];
      end
    end
  end

  always @(posedge sclk) begin
    if (cs_n === 1'b0 && nfall > 0) begin
      check(($realtime - t_last_edge) > 24.9 && ($realtime - t_last_edge) < 25.1,
            "R3 sclk low phase ns", $rtoi($realtime - t_last_edge), 25);
      check(($realtime - t_last_fall) >= 5.0, "R4 mosi hold ns", $rtoi($realtime - t_last_fall), 5);
      t_last_edge = $realtime;
    end
  end

  always @(posedge cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      was_frame = 1;
      check(nfall == 16, "R2 falling edges per frame", nfall, 16);
      check(($realtime - t_last_fall) >= 20.0, "R7 cs hold ns", $rtoi($realtime - t_last_fall), 20);
      check(rx_ctrl == cur.ctrl, "R4 control word received", rx_ctrl, cur.ctrl);
      t_cs_rise = $realtime;
      down = rx_ctrl[4];
      if (down) t_down = $realtime;
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(done == 1'b0, "R8 done width", done, 0);
      if (done) begin
        item_t it;
        check(done_q.size() != 0, "R11 unexpected done", done_q.size(), 1);
        if (done_q.size() != 0) begin
          it = done_q.pop_front();
          check(rx_word == it.resp, "R5 rx_word", rx_word, it.resp);
          check(result == it.exp_result, "R10 result", result, it.exp_result);
          check(result_signed == it.exp_signed, "R10 result_signed", result_signed, it.exp_signed);
          check(busy == 1'b1, "R8 busy through quiet", busy, 1);
        end
      end
    end
    prev_done = done;
  end

  // ---------------- driver ----------------
  task automatic run_frame(input logic [15:0] ctrl, input logic [15:0] resp, input bit intrude);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.ctrl = ctrl;
    it.resp = resp;
    it.exp_signed = !ctrl[0];
    it.exp_result = ctrl[0] ? {4'h0, resp[11:0]} : {{4{resp[11]}}, resp[11:0]};
    done_q.push_back(it);
    model_q.push_back(it);
    pushed++;
    ctrl_word = ctrl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (30) @(negedge clk);
      ctrl_word = 16'hDEAD;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    check(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    t_down = $realtime;
    @(negedge clk);
    check(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {cs_n, busy}, 2);

    run_frame(16'hC3A0, 16'h1F23, 0);   // two's complement, negative sample
    run_frame(16'h5A01, 16'h2ABC, 0);   // straight binary, bit 11 set
    run_frame(16'h0011, 16'h3012, 0);   // straight, power-down request
    run_frame(16'hFFEE, 16'h07FF, 1);   // after power-down; start while busy
    run_frame(16'h0000, 16'hFFFF, 0);   // two's complement, all ones
    run_frame(16'h0001, 16'h0800, 0);   // straight, mid-scale
    run_frame(16'h8000, 16'h0800, 0);   // two's complement, most negative

    @(negedge clk);
    while (busy || done_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(frames_seen == pushed, "R11 frames run", frames_seen, pushed);
    check(done_q.size() == 0, "R11 pending results", done_q.size(), 0);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

endmodule